// File: doc/BRIEF.md
# Pipelined Burst Address/Data Sequencer

This block is the master-side engine of a pipelined bus, where the address phase of one transfer overlaps the data phase of another. Requests arrive on a valid/ready handshake. Each request carries a 32-bit address, a 2-bit burst kind and a packed vector of up to four 32-bit words. The cycle after a request is taken, the sequencer spends exactly one slot on that request's address phase. It then moves the request into a four-entry pending queue.

The head of the queue is serialized onto a data channel with its own valid/ready handshake, one word per accepted beat. Each beat shows the address of the request it belongs to. Because a request is parked in the queue after its address slot, the next request can be taken and addressed while older bursts are still streaming out. Bursts never interleave on the data channel: they leave in the order they were accepted.

A request whose kind is reserved is taken off the request port and dropped without trace. A synchronous reset clears the queue and idles both output channels.

Top module: `burstSequencer`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `addrValid` and `dataValid` are 0 and `reqReady` is 1.
- R2: A request is accepted at a clock edge where `reqValid` and `reqReady` are both 1. For an accepted request of kind 00, 01 or 10, `addrValid` is 1 for exactly one cycle, starting after that edge, with `addrOut` equal to the request address and `addrKind` equal to its kind.
- R3: With room in the queue, requests presented on consecutive cycles are accepted on consecutive edges, even while the data channel is stalled.
- R4: Kind 00 produces 1 data beat, kind 01 produces 2 and kind 10 produces 4. `dataLast` is 1 exactly on a request's final beat.
- R5: Within a burst, word i is taken from `reqWords[32*i +: 32]`, and words leave in increasing i starting at 0.
- R6: All beats of an earlier request leave before any beat of a later one. Every beat leaves exactly once.
- R7: During every beat, `dataAddr` equals the address of the request that beat belongs to.
- R8: A beat transfers only at an edge where `dataValid` and `dataReady` are both 1. While `dataReady` is 0, `dataValid`, `dataOut`, `dataAddr` and `dataLast` hold their values.
- R9: A request of kind 11 is accepted but produces no address phase and no data beats.
- R10: `reqReady` is 0 whenever the queue plus the request in its address slot together hold four requests.
- R11: A request's first data beat appears no earlier than the cycle after its address phase.
- R12: A reset asserted in the middle of a burst discards all pending beats. Only requests accepted after the reset produce output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqAddr | input | 32 | Request address |
| reqKind | input | 2 | Burst kind: 00 one beat, 01 two, 10 four, 11 reserved |
| reqWords | input | 128 | Burst words, word i at bits 32*i+31:32*i |
| addrValid | output | 1 | Address phase slot |
| addrOut | output | 32 | Address of the request in its address phase |
| addrKind | output | 2 | Kind of the request in its address phase |
| dataValid | output | 1 | Data beat present |
| dataReady | input | 1 | Receiver takes the beat |
| dataOut | output | 32 | Beat word |
| dataAddr | output | 32 | Address of the request owning the beat |
| dataLast | output | 1 | Final beat of the burst |

## Verification
Several properties are checked on every cycle:
- each address slot follows an accepted, non-reserved request and mirrors its address and kind;
- a stalled beat stays frozen;
- the beat address holds steady across a burst;
- bursts end after one, two or four beats;
- reset leaves both channels idle.

Only the bench scenarios can show the rest:
- that word order matches the request vector;
- that bursts queued behind a long stall leave in acceptance order;
- that reserved requests vanish;
- that a mid-burst reset discards everything pending;
- that the ready signal drops at exactly four outstanding requests.

// File: rtl/burstSeqPkg.sv
package burstSeqPkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int MAX_BEATS = 4;
  localparam int Q_DEPTH   = 4;
  localparam int PTR_W     = $clog2(Q_DEPTH);
  localparam int BEAT_W    = $clog2(MAX_BEATS);

  typedef enum logic [1:0] {
    KIND_ONE  = 2'b00,
    KIND_TWO  = 2'b01,
    KIND_FOUR = 2'b10,
    KIND_RSVD = 2'b11
  } burstKind_e;

  typedef struct packed {
    logic              stageLoad;
    logic              push;
    logic              pop;
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [BEAT_W-1:0] beatIdx;
  } seqStrobes_t;

  // index of the final beat for a kind
  function automatic logic [BEAT_W-1:0] lastIdx(input logic [1:0] k);
    case (k)
      KIND_ONE: lastIdx = BEAT_W'(0);
      KIND_TWO: lastIdx = BEAT_W'(1);
      default:  lastIdx = BEAT_W'(MAX_BEATS - 1);
    endcase
  endfunction
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import burstSeqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              dataReady,
  input  logic [BEAT_W-1:0] headLen,
  output logic              reqReady,
  output logic              addrValid,
  output logic              dataValid,
  output logic              dataLast,
  output seqStrobes_t       strobes
);
  localparam int CNT_W = PTR_W + 2;

  logic [PTR_W:0]    fill;
  logic              stageValid;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [BEAT_W-1:0] beatIdx;
  logic              accept, good, beatAdv, atLast, pop;

  always_comb begin
    reqReady  = ({1'b0, fill} + CNT_W'(stageValid)) < CNT_W'(Q_DEPTH);
    accept    = reqValid && reqReady;
    good      = accept && (reqKind != KIND_RSVD);
    dataValid = (fill != '0);
    beatAdv   = dataValid && dataReady;
    atLast    = (beatIdx == headLen);
    pop       = beatAdv && atLast;
    dataLast  = dataValid && atLast;
    addrValid = stageValid;
    strobes.stageLoad = good;
    strobes.push      = stageValid;
    strobes.pop       = pop;
    strobes.wrPtr     = wrPtr;
    strobes.rdPtr     = rdPtr;
    strobes.beatIdx   = beatIdx;
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    nextPtr = (p == PTR_W'(Q_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      fill       <= '0;
      stageValid <= 1'b0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      beatIdx    <= '0;
    end else begin
      stageValid <= good;
      if (stageValid) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      case ({stageValid, pop})
        2'b10:   fill <= fill + (PTR_W+1)'(1);
        2'b01:   fill <= fill - (PTR_W+1)'(1);
        default: fill <= fill;
      endcase
      if (pop)          beatIdx <= '0;
      else if (beatAdv) beatIdx <= beatIdx + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/seqPath.sv
module seqPath
  import burstSeqPkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  seqStrobes_t                 strobes,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [1:0]                  reqKind,
  input  logic [MAX_BEATS*DATA_W-1:0] reqWords,
  output logic [ADDR_W-1:0]           addrOut,
  output logic [1:0]                  addrKind,
  output logic [DATA_W-1:0]           dataOut,
  output logic [ADDR_W-1:0]           dataAddr,
  output logic [BEAT_W-1:0]           headLen
);
  logic [DATA_W-1:0] inWord [MAX_BEATS];
  logic [DATA_W-1:0] stWord [MAX_BEATS];
  logic [ADDR_W-1:0] stAddr;
  logic [1:0]        stKind;

  logic [ADDR_W-1:0] qAddr [Q_DEPTH];
  logic [BEAT_W-1:0] qLen  [Q_DEPTH];
  logic [DATA_W-1:0] qWord [Q_DEPTH][MAX_BEATS];

  for (genvar b = 0; b < MAX_BEATS; b++) begin : gSplit
    assign inWord[b] = reqWords[b*DATA_W +: DATA_W];
  end

  // address slot register
  always_ff @(posedge clk) begin
    if (rst) begin
      stAddr <= '0;
      stKind <= '0;
      for (int b = 0; b < MAX_BEATS; b++) stWord[b] <= '0;
    end else if (strobes.stageLoad) begin
      stAddr <= reqAddr;
      stKind <= reqKind;
      for (int b = 0; b < MAX_BEATS; b++) stWord[b] <= inWord[b];
    end
  end

  // pending burst storage, written from the address slot
  always_ff @(posedge clk) begin
    if (strobes.push) begin
      qAddr[strobes.wrPtr] <= stAddr;
      qLen[strobes.wrPtr]  <= lastIdx(stKind);
      for (int b = 0; b < MAX_BEATS; b++) qWord[strobes.wrPtr][b] <= stWord[b];
    end
  end

  always_comb begin
    addrOut  = stAddr;
    addrKind = stKind;
    dataOut  = qWord[strobes.rdPtr][strobes.beatIdx];
    dataAddr = qAddr[strobes.rdPtr];
    headLen  = qLen[strobes.rdPtr];
  end
endmodule

// File: rtl/burstSequencer.sv
module burstSequencer
  import burstSeqPkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [1:0]                  reqKind,
  input  logic [MAX_BEATS*DATA_W-1:0] reqWords,
  output logic                        addrValid,
  output logic [ADDR_W-1:0]           addrOut,
  output logic [1:0]                  addrKind,
  output logic                        dataValid,
  input  logic                        dataReady,
  output logic [DATA_W-1:0]           dataOut,
  output logic [ADDR_W-1:0]           dataAddr,
  output logic                        dataLast
);
  seqStrobes_t       strobes;
  logic [BEAT_W-1:0] headLen;

  seqCtrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .dataReady(dataReady), .headLen(headLen), .reqReady(reqReady),
    .addrValid(addrValid), .dataValid(dataValid), .dataLast(dataLast),
    .strobes(strobes)
  );

  seqPath u_path (
    .clk(clk), .rst(rst), .strobes(strobes), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWords(reqWords), .addrOut(addrOut),
    .addrKind(addrKind), .dataOut(dataOut), .dataAddr(dataAddr),
    .headLen(headLen)
  );
endmodule

// File: rtl/burstSeqChecker.sv
module burstSeqChecker
  import burstSeqPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqKind,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrOut,
  input logic [1:0]        addrKind,
  input logic              dataValid,
  input logic              dataReady,
  input logic [DATA_W-1:0] dataOut,
  input logic [ADDR_W-1:0] dataAddr,
  input logic              dataLast
);
  logic [BEAT_W:0] beatCnt;

  always_ff @(posedge clk) begin
    if (rst) beatCnt <= '0;
    else if (dataValid && dataReady) beatCnt <= dataLast ? '0 : beatCnt + (BEAT_W+1)'(1);
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!addrValid && !dataValid && reqReady));

  a_r2_addr_after_accept: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> $past(reqValid && reqReady && reqKind != 2'b11));

  a_r2_addr_fields: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> (addrOut == $past(reqAddr) && addrKind == $past(reqKind)));

  a_r9_no_reserved_slot: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> addrKind != 2'b11);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (dataValid && !dataReady) |=> (dataValid && $stable(dataOut) &&
                                   $stable(dataAddr) && $stable(dataLast)));

  a_r7_beat_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (dataValid && dataReady && !dataLast) |=> (dataValid && $stable(dataAddr)));

  a_r4_burst_length: assert property (@(posedge clk) disable iff (rst)
    (dataValid && dataReady && dataLast) |->
      (beatCnt == 0 || beatCnt == 1 || beatCnt == (BEAT_W+1)'(MAX_BEATS - 1)));
endmodule

bind burstSequencer burstSeqChecker i_burstSeqChecker (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqKind(reqKind), .addrValid(addrValid),
  .addrOut(addrOut), .addrKind(addrKind), .dataValid(dataValid),
  .dataReady(dataReady), .dataOut(dataOut), .dataAddr(dataAddr),
  .dataLast(dataLast)
);

// File: tb/test_burstSequencer.sv
module test_burstSequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst = 1'b1;
  logic         reqValid = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic [1:0]   reqKind = '0;
  logic [127:0] reqWords = '0;
  logic         dataReady = 1'b0;
  logic         reqReady, addrValid, dataValid, dataLast;
  logic [31:0]  addrOut, dataOut, dataAddr;
  logic [1:0]   addrKind;

  burstSequencer i_burstSequencer (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqWords(reqWords),
    .addrValid(addrValid), .addrOut(addrOut), .addrKind(addrKind),
    .dataValid(dataValid), .dataReady(dataReady), .dataOut(dataOut),
    .dataAddr(dataAddr), .dataLast(dataLast)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic        last;
    logic        first;
    logic [15:0] rn;
  } expBeat_t;

  expBeat_t    expQ[$];
  logic [33:0] addrQ[$];
  int checks = 0, fails = 0;
  int reqNum = 0, addrSeen = 0;
  expBeat_t    monB;
  logic [33:0] monA;

  // vector: {kind, addr, w3, w2, w1, w0}
  localparam logic [161:0] VEC [8] = '{
    {2'b00, 32'h0000_1000, 32'h0, 32'h0, 32'h0, 32'hA000_0001},
    {2'b01, 32'h0000_2000, 32'h0, 32'h0, 32'hB000_0002, 32'hB000_0001},
    {2'b10, 32'h0000_3000, 32'hC000_0004, 32'hC000_0003, 32'hC000_0002, 32'hC000_0001},
    {2'b11, 32'h0000_4000, 32'hDEAD_0004, 32'hDEAD_0003, 32'hDEAD_0002, 32'hDEAD_0001},
    {2'b10, 32'h0000_5000, 32'h5000_0044, 32'h5000_0033, 32'h5000_0022, 32'h5000_0011},
    {2'b00, 32'h0000_6000, 32'h0, 32'h0, 32'h0, 32'h6000_00FF},
    {2'b01, 32'h0000_7000, 32'h0, 32'h0, 32'h7000_0BBB, 32'h7000_0AAA},
    {2'b10, 32'hFFFF_FFFC, 32'h8888_0004, 32'h8888_0003, 32'h8888_0002, 32'h8888_0001}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: beats first, then the address slot of this cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (dataValid && dataReady) begin
        if (expQ.size() == 0) check(1'b0, "R6 unexpected beat", dataOut, 0);
        else begin
          monB = expQ.pop_front();
          check(dataOut == monB.d, "R5 beat word", dataOut, monB.d);
          check(dataAddr == monB.a, "R7 beat address", dataAddr, monB.a);
          check(dataLast == monB.last, "R4 last flag", dataLast, monB.last);
          if (monB.first) check(int'(monB.rn) < addrSeen, "R11 data after address", monB.rn, addrSeen);
        end
      end
      if (addrValid) begin
        if (addrQ.size() == 0) check(1'b0, "R9 extra address phase", {addrKind, addrOut}, 0);
        else begin
          monA = addrQ.pop_front();
          check({addrKind, addrOut} == monA, "R2 address phase", {addrKind, addrOut}, monA);
        end
        addrSeen++;
      end
    end
  end

  // called just after a rising edge; returns after the accepting edge
  task automatic sendReq(input logic [161:0] v, output int waits);
    int n;
    reqKind  = v[161:160];
    reqAddr  = v[159:128];
    reqWords = v[127:0];
    reqValid = 1'b1;
    waits = 0;
    @(negedge clk);
    while (!reqReady) begin
      waits++;
      @(negedge clk);
    end
    n = (v[161:160] == 2'b00) ? 1 : (v[161:160] == 2'b01) ? 2 : (v[161:160] == 2'b10) ? 4 : 0;
    if (n != 0) begin
      addrQ.push_back(v[161:128]);
      for (int i = 0; i < n; i++)
        expQ.push_back({v[159:128], v[32*i +: 32], (i == n-1), (i == 0), 16'(reqNum)});
      reqNum++;
    end
    @(posedge clk);
    #2 reqValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    expQ.delete();
    addrQ.delete();
    reqNum = 0;
    addrSeen = 0;
    @(negedge clk);
    check(!addrValid && !dataValid && reqReady, "R1 idle after reset",
          {addrValid, dataValid, reqReady}, 3'b001);
    @(posedge clk);
    #2;
  endtask

  task automatic drain();
    dataReady = 1'b1;
    for (int i = 0; i < 300 && (expQ.size() != 0 || addrQ.size() != 0); i++) @(posedge clk);
    #2;
    check(expQ.size() == 0, "R6 all beats delivered", expQ.size(), 0);
    check(addrQ.size() == 0, "R2 all address phases seen", addrQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w;
    @(posedge clk);
    #2;
    doReset();

    // table walk, free-flowing then with a stalling receiver
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 8; i++) begin
        dataReady = (pass == 0) ? 1'b1 : (i % 3 != 0);
        sendReq(VEC[i], w);
      end
      drain();
    end

    // R3 and R10: receiver stalled, four requests back to back
    dataReady = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sendReq(VEC[(i == 3) ? 7 : i], w);
      check(w == 0, "R3 back-to-back accept", w, 0);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!reqReady, "R10 ready low when four outstanding", reqReady, 0);
      check(dataValid && dataOut == expQ[0].d, "R8 stalled beat held", dataOut, expQ[0].d);
    end
    @(posedge clk);
    #2;
    drain();
    @(negedge clk);
    check(reqReady, "R10 ready back after drain", reqReady, 1);
    @(posedge clk);
    #2;

    // R9: reserved kind leaves no trace
    sendReq(VEC[3], w);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!addrValid && !dataValid, "R9 reserved request dropped", {addrValid, dataValid}, 0);
    end
    @(posedge clk);
    #2;

    // R12: reset in the middle of a stalled quad burst
    dataReady = 1'b0;
    sendReq(VEC[2], w);
    repeat (3) @(posedge clk);
    #2;
    doReset();
    sendReq(VEC[5], w);
    drain();
    check(reqNum == 1 && addrSeen == 1, "R12 only post-reset request seen", addrSeen, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule